// File: doc/BRIEF.md
# Buffered Output-Compare PWM Timer

This block is a pulse-width modulator built on an up-counter. The counter advances once per prescaled tick, runs from zero up to a programmable top value, then overflows back to zero. Two compare registers are checked against the counter. On an overflow the output pin can toggle. On a compare match the pin is driven to a fixed level, low or high as the polarity bit chooses. The top value sets the period and the compare value sets the pulse width.

The two compare channels can run on their own, each on its own pin. They can also be linked so that both take turns driving the channel 0 pin. When linked, the register written most recently takes control at the next overflow. Software can therefore load a new duty value into the idle register without producing a glitch. While linked, the channel 1 pin is released and its drive enable is low.

Top module: `pwm_buf_timer`

## Requirements
- R1: After reset both pins are low, the channel 1 drive enable is high and channel 0 is the active linked register. The top value resets to all ones, so with only toggle and a compare of 2 programmed, the pin stays low for hundreds of cycles.
- R2: The write port decodes four addresses: 0 is the top value, 1 is compare 0, 2 is compare 1 and 3 is control. A counter at or above the top value overflows to zero on the next tick, so the period is (top + 1) ticks. With top 9 and no prescaling the period is 10 clocks.
- R3: The control bits are: bit 0 links the channels, bit 1 enables toggle on overflow, bit 2 selects high-pulse polarity and bits 5:3 select the prescaler. With toggle on and high polarity, the pin is high for exactly compare-value ticks after each overflow. Compare 3 with top 9 gives 3 high clocks per 10.
- R4: With low polarity (bit 2 clear) a match sets the pin and the overflow toggle clears it, so the pin is low for compare-value ticks. Compare 3 with top 9 gives 7 high clocks per 10.
- R5: A prescaler select n gives one counter tick every 2^n bus clocks. Select 2 with top 4 and compare 2 gives a period of 20 clocks with 8 high.
- R6: A compare value above the top value never matches, so the pin only toggles at each overflow. Top 7 with compare 20 gives a period of 16 clocks with 8 high.
- R7: A compare value of 0 matches at the overflow itself, and the match wins over the toggle, so the pin stays low.
- R8: When the channels are linked (control bit 0 set), compare 0 drives the channel 0 pin first.
- R9: A write to the idle compare 1 register while linked does not change the pulse in progress. Compare 1 takes control from the next overflow.
- R10: At each overflow while linked, the register written last controls the pin, so writing compare 0 hands control back to it.
- R11: A write to the active compare register while linked takes effect within the current period.
- R12: While linked, channel 1's drive enable is low and its pin is low. While unlinked, channel 1 drives its own pin from compare 1 (compare 5 with top 9 gives 5 high clocks per 10).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 top, 1 compare 0, 2 compare 1, 3 control |
| wrData | input | 16 | Write data |
| ch0Out | output | 1 | Channel 0 pin, the output of a linked pair |
| ch1Out | output | 1 | Channel 1 pin |
| ch1OutEn | output | 1 | Channel 1 drive enable, low while linked |

## Verification
A register write takes effect on the clock edge that captures it. A pin changes on the tick edge at which the counter reaches its next value, so the pin's period and high time follow the tick count, with no fixed delay after a write. The scoreboard therefore measures whole periods from one rising edge to the next. Each expected item is pushed only after several periods of settling, which keeps the measurement clear of the transition that follows a reconfiguration. The handover checks (R9, R11) are timed from a sampled rising edge: the write lands one edge later, when the counter reads 1. The high time of that same pulse is then counted, to show whether the write changed it.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  typedef struct packed {
    logic ldMod;
    logic ldCmp0;
    logic ldCmp1;
    logic ldCtrl;
  } wrStrb_t;

  typedef struct packed {
    logic tick;
    logic wrap;
    logic hit0;
    logic hit1;
  } cntStat_t;

  typedef struct packed {
    logic [2:0] presSel;
    logic       polHigh;
    logic       togEn;
    logic       link;
  } ctrlReg_t;

  localparam int CTRL_W = $bits(ctrlReg_t);

endpackage

// File: rtl/pwm_tmr_datapath.sv
module pwm_tmr_datapath
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrb_t          strb,
  input  logic [CNT_W-1:0] wrData,
  output cntStat_t         stat,
  output ctrlReg_t         ctrl
);

  localparam int PRE_W = (1 << PRE_SEL_W) - 1;

  logic [CNT_W-1:0] cnt, modReg, cmp0Reg, cmp1Reg, nextCnt;
  logic [PRE_W-1:0] preCnt, preMask;
  logic tick, atTop;

  // prescaler: tick when the low n bits of a free-running counter are all ones
  assign preMask = ~({PRE_W{1'b1}} << ctrl.presSel);
  assign tick    = (preCnt & preMask) == preMask;

  assign atTop   = cnt >= modReg;
  assign nextCnt = atTop ? '0 : cnt + 1'b1;

  assign stat.tick = tick;
  assign stat.wrap = tick && atTop;
  assign stat.hit0 = tick && (nextCnt == cmp0Reg);
  assign stat.hit1 = tick && (nextCnt == cmp1Reg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      cnt     <= '0;
      modReg  <= '1;
      cmp0Reg <= '1;
      cmp1Reg <= '1;
      ctrl    <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
      if (tick) cnt <= nextCnt;
      if (strb.ldMod)  modReg  <= wrData;
      if (strb.ldCmp0) cmp0Reg <= wrData;
      if (strb.ldCmp1) cmp1Reg <= wrData;
      if (strb.ldCtrl) ctrl    <= ctrlReg_t'(wrData[CTRL_W-1:0]);
    end
  end

  a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
    (tick && ctrl.presSel != 0) |=> (!tick || ctrl.presSel != $past(ctrl.presSel)));

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    stat.wrap |=> (cnt == 0));

endmodule

// File: rtl/pwm_tmr_control.sv
module pwm_tmr_control
  import pwm_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic       wrLinkBit,
  input  cntStat_t   stat,
  input  ctrlReg_t   ctrl,
  output wrStrb_t    strb,
  output logic       ch0Out,
  output logic       ch1Out,
  output logic       ch1OutEn
);

  logic activeSel, pendingSel, linkRise, useSel, ch0Hit;
  logic ch0Next, ch1Next;

  always_comb begin
    strb        = '0;
    strb.ldMod  = wrEn && wrAddr == 2'd0;
    strb.ldCmp0 = wrEn && wrAddr == 2'd1;
    strb.ldCmp1 = wrEn && wrAddr == 2'd2;
    strb.ldCtrl = wrEn && wrAddr == 2'd3;
  end

  assign linkRise = strb.ldCtrl && wrLinkBit && !ctrl.link;
  // the register in control after this edge decides the match
  assign useSel   = stat.wrap ? pendingSel : activeSel;
  assign ch0Hit   = ctrl.link ? (useSel ? stat.hit1 : stat.hit0) : stat.hit0;

  function automatic logic pinStep(logic cur, logic hit, logic wrap, ctrlReg_t c);
    if (hit)             return !c.polHigh;
    if (wrap && c.togEn) return !cur;
    return cur;
  endfunction

  assign ch0Next  = pinStep(ch0Out, ch0Hit, stat.wrap, ctrl);
  assign ch1Next  = ctrl.link ? 1'b0 : pinStep(ch1Out, stat.hit1, stat.wrap, ctrl);
  assign ch1OutEn = !ctrl.link;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeSel  <= 1'b0;
      pendingSel <= 1'b0;
      ch0Out     <= 1'b0;
      ch1Out     <= 1'b0;
    end else begin
      ch0Out <= ch0Next;
      ch1Out <= ch1Next;
      if (linkRise) begin
        activeSel  <= 1'b0;
        pendingSel <= 1'b0;
      end else begin
        if (ctrl.link && stat.wrap) activeSel <= pendingSel;
        if (strb.ldCmp0)      pendingSel <= 1'b0;
        else if (strb.ldCmp1) pendingSel <= 1'b1;
      end
    end
  end

  a_r9_handover_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (activeSel != $past(activeSel)) |-> ($past(stat.wrap) || $past(linkRise)));

  a_r12_ch1_released: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.link |=> !ch1Out);

  a_r2_pin_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ch0Out) |-> $past(stat.tick));

endmodule

// File: rtl/pwm_buf_timer.sv
module pwm_buf_timer
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic             ch0Out,
  output logic             ch1Out,
  output logic             ch1OutEn
);

  wrStrb_t  strb;
  cntStat_t stat;
  ctrlReg_t ctrl;

  pwm_tmr_datapath #(.CNT_W(CNT_W), .PRE_SEL_W(PRE_SEL_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .stat(stat), .ctrl(ctrl)
  );

  pwm_tmr_control uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrLinkBit(wrData[0]), .stat(stat), .ctrl(ctrl), .strb(strb),
    .ch0Out(ch0Out), .ch1Out(ch1Out), .ch1OutEn(ch1OutEn)
  );

endmodule

// File: tb/tb_pwm_buf_timer.sv
`timescale 1ns/1ps
module tb_pwm_buf_timer;

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [1:0] wrAddr = 0;
  logic [15:0] wrData = 0;
  logic ch0Out, ch1Out, ch1OutEn;

  int nChk = 0, nFail = 0;
  bit done = 0;

  typedef struct { int hi; int per; string tag; } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  pwm_buf_timer dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .ch0Out(ch0Out), .ch1Out(ch1Out), .ch1OutEn(ch1OutEn));

  function automatic logic pinOf(int sel);
    return sel == 0 ? ch0Out : ch1Out;
  endfunction

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doWrite(int addr, int data);
    wrAddr = addr[1:0];
    wrData = data[15:0];
    wrEn = 1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic waitRise(int sel);
    logic prev;
    prev = pinOf(sel);
    forever begin
      @(negedge clk);
      if (!prev && pinOf(sel)) break;
      prev = pinOf(sel);
    end
  endtask

  task automatic measure(int sel, output int hi, output int per);
    logic prev;
    waitRise(sel);
    hi = 0; per = 0;
    do begin
      per++;
      if (pinOf(sel)) hi++;
      prev = pinOf(sel);
      @(negedge clk);
    end while (!(!prev && pinOf(sel)));
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushExp(int hi, int per, string tag);
    expItem_t it;
    it.hi = hi; it.per = per; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
  endtask

  task automatic countCurrent(int addr, int data, output int hi);
    waitRise(0);
    hi = 1;
    doWrite(addr, data);
    while (ch0Out) begin
      hi++;
      @(negedge clk);
    end
  endtask

  // scoreboard monitor
  initial begin
    int hi, per;
    expItem_t it;
    forever begin
      wait (expQ.size() > 0);
      measure(0, hi, per);
      it = expQ[0];
      check({it.tag, " high"}, hi, it.hi);
      check({it.tag, " period"}, per, it.per);
      void'(expQ.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    int hi, per, bad;
    settle(3);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 ch0Out", ch0Out, 0);
    check("R1 ch1Out", ch1Out, 0);
    check("R1 ch1OutEn", ch1OutEn, 1);
    doWrite(3, 6'b000110);
    doWrite(1, 2);
    bad = 0;
    repeat (300) begin @(negedge clk); if (ch0Out) bad++; end
    check("R1 high samples with max top", bad, 0);

    // R2 R3 basic PWM
    doWrite(0, 9);
    doWrite(1, 3);
    doWrite(2, 5);
    settle(60);
    pushExp(3, 10, "R2/R3");
    // R12 unlinked channel 1
    measure(1, hi, per);
    check("R12 ch1 high", hi, 5);
    check("R12 ch1 period", per, 10);

    // R4 low polarity
    doWrite(3, 6'b000010);
    settle(60);
    pushExp(7, 10, "R4");

    // R7 zero compare
    doWrite(3, 6'b000110);
    doWrite(1, 0);
    settle(30);
    bad = 0;
    repeat (40) begin @(negedge clk); if (ch0Out) bad++; end
    check("R7 high samples", bad, 0);

    // R5 prescaler
    doWrite(0, 4);
    doWrite(1, 2);
    doWrite(3, 6'b010110);
    settle(100);
    pushExp(8, 20, "R5");

    // R6 compare above top
    doWrite(3, 6'b000110);
    doWrite(0, 7);
    doWrite(1, 20);
    settle(60);
    pushExp(8, 16, "R6");

    // linked mode
    doWrite(0, 9);
    doWrite(1, 3);
    doWrite(3, 6'b000111);
    check("R12 ch1OutEn linked", ch1OutEn, 0);
    settle(2);
    check("R12 ch1Out linked", ch1Out, 0);
    settle(60);
    pushExp(3, 10, "R8");

    // R9 idle write waits for overflow
    countCurrent(2, 6, hi);
    check("R9 pulse in progress", hi, 3);
    pushExp(6, 10, "R9");

    // R11 write to active register is immediate
    countCurrent(2, 8, hi);
    check("R11 active write", hi, 8);

    // R10 last written wins at overflow
    doWrite(1, 2);
    settle(30);
    pushExp(2, 10, "R10");

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule